// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Selection

This block watches a running BCD clock (hundredths, seconds, minutes, hours, date, month and weekday) that a separate timekeeping counter supplies. It also takes a strobe that pulses once for each hundredths step. It compares that time against an alarm time held in a small register file. On the strobe, a match sets an alarm flag and can drive an active-low interrupt line. A repeat code picks which calendar fields take part in the match, so one alarm time can fire yearly, monthly, weekly, daily, hourly, every minute or every second. In the per-second setting, two special alarm-hundredths values give a periodic alarm every tenth or every hundredth of a second.

The host programs the block through a plain register port: a write strobe with address and data, and a combinational read-data output. The interrupt line is driven by a three-state machine. `IRQ_QUIET` is the idle state with the line high. `IRQ_PULSE` holds the line low for one tick period. `IRQ_HOLD` holds the line low for as long as the flag and the enable are both set. The transitions are:
- `IRQ_QUIET` to `IRQ_PULSE` on a new match while enabled in pulse mode.
- `IRQ_QUIET` to `IRQ_HOLD` when the flag and the enable are both 1 in level mode.
- `IRQ_PULSE` to `IRQ_QUIET` at the next tick with no new match, or when the enable drops.
- `IRQ_PULSE` to `IRQ_HOLD` or `IRQ_QUIET` when the mode is switched to level.
- `IRQ_HOLD` to `IRQ_QUIET` once the flag, the enable or level mode goes away.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_n` is 1.
- R2: The alarm bytes read back as written at addresses 0x08..0x0E, in this order: hundredths, seconds, minutes, hours, date, month, weekday. The repeat code is held in bits [4:2] of address 0x18. The interrupt enable is bit 2 of address 0x12 and the interrupt mode is bits [6:5] of address 0x12. Unused bits read 0.
- R3: While the repeat code is 0 the alarm flag is never set.
- R4: Hundredths are always compared. The other fields are compared according to the repeat code:
  - seconds for codes 1..6;
  - minutes for codes 1..5;
  - hours for codes 1..4;
  - date for codes 1 and 2;
  - month for code 1 only;
  - weekday for code 3 only.
- R5: The hours comparison uses the whole byte, so bit 5 (the PM indicator in 12-hour mode) must also match.
- R6: With repeat code 7 and alarm hundredths 0xFF, every tick that carries a new hundredths value sets the flag.
- R7: With repeat code 7 and an alarm hundredths upper nibble of 0xF, only the low BCD digit of the hundredths is compared.
- R8: Matching is evaluated only on a tick. A tick that repeats the hundredths value of a previous matching tick does not set the flag again.
- R9: The flag is bit 2 of address 0x0F. Writing 0 to that bit clears it. Writing 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R10: In level mode (mode 0), `irq_n` is low exactly when the flag and the enable are both 1. It follows them from the same clock edge.
- R11: In pulse mode (mode not 0), a match drives `irq_n` low until the next tick without a new match. After that `irq_n` is high even though the flag stays set.
- R12: While the enable is 0, `irq_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per hundredths step |
| cur_hund | input | 8 | Current hundredths, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, bit 5 = PM in 12-hour mode |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_wday | input | 8 | Current weekday |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions check the following on every cycle:
- the flag rises only after a tick and only with a non-zero repeat code;
- in level mode the interrupt line agrees with the flag and the enable;
- the line is never low while the enable is off;
- a pulse starts only on a new match.

The field selection for each repeat code, the two wildcard hundredths encodings, the PM bit, and the stalled-tick rule can only be shown by the bench's scenarios. So can the clear-versus-match priority and the pulse length measured in ticks. The bench sweeps one mismatched field at a time across every repeat code.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int NFIELD       = 7;
    localparam int ADR_ALM_BASE = 'h08;
    localparam int ADR_STAT     = 'h0F;
    localparam int ADR_IMSK     = 'h12;
    localparam int ADR_TCTL     = 'h18;
    localparam int FLAG_BIT     = 2;
    localparam int AIE_BIT      = 2;
    localparam int RPT_LSB      = 2;
    localparam int IM_LSB       = 5;
    localparam logic [2:0] RPT_PER_SEC = 3'd7;

    typedef enum logic [1:0] {IRQ_QUIET, IRQ_PULSE, IRQ_HOLD} irq_state_e;

    // lane order: 0 hund, 1 sec, 2 min, 3 hour, 4 date, 5 month, 6 wday
    function automatic logic [NFIELD-1:0] field_use(input logic [2:0] rpt);
        case (rpt)
            3'd1:    field_use = 7'b0111111;
            3'd2:    field_use = 7'b0011111;
            3'd3:    field_use = 7'b1001111;
            3'd4:    field_use = 7'b0001111;
            3'd5:    field_use = 7'b0000111;
            3'd6:    field_use = 7'b0000011;
            3'd7:    field_use = 7'b0000001;
            default: field_use = 7'b0000000;
        endcase
    endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DW     = 8,
    parameter int NF     = NFIELD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              hit,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     alm_o [NF],
    output logic [2:0]        rpt_o,
    output logic              flag_q,
    output logic              aie_q,
    output logic [1:0]        im_q,
    output logic              flag_nxt,
    output logic              aie_nxt,
    output logic [1:0]        im_nxt
);
    logic [DW-1:0] alm_q [NF];
    logic          wr_stat, wr_imsk, wr_tctl;

    assign wr_stat = we && (addr == ADDR_W'(ADR_STAT));
    assign wr_imsk = we && (addr == ADDR_W'(ADR_IMSK));
    assign wr_tctl = we && (addr == ADDR_W'(ADR_TCTL));

    for (genvar i = 0; i < NF; i++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[i] <= '0;
            else if (we && (addr == ADDR_W'(ADR_ALM_BASE + i)))
                alm_q[i] <= wdata;
        end
        assign alm_o[i] = alm_q[i];
    end

    always_comb begin
        if (hit)
            flag_nxt = 1'b1;
        else if (wr_stat && !wdata[FLAG_BIT])
            flag_nxt = 1'b0;
        else
            flag_nxt = flag_q;
        aie_nxt = wr_imsk ? wdata[AIE_BIT] : aie_q;
        im_nxt  = wr_imsk ? wdata[IM_LSB+1:IM_LSB] : im_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            aie_q  <= 1'b0;
            im_q   <= 2'b00;
            rpt_o  <= 3'd0;
        end else begin
            flag_q <= flag_nxt;
            aie_q  <= aie_nxt;
            im_q   <= im_nxt;
            if (wr_tctl)
                rpt_o <= wdata[RPT_LSB+2:RPT_LSB];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NF; i++)
            if (addr == ADDR_W'(ADR_ALM_BASE + i))
                rdata = alm_q[i];
        if (addr == ADDR_W'(ADR_STAT))
            rdata[FLAG_BIT] = flag_q;
        if (addr == ADDR_W'(ADR_IMSK)) begin
            rdata[AIE_BIT]             = aie_q;
            rdata[IM_LSB+1:IM_LSB]     = im_q;
        end
        if (addr == ADDR_W'(ADR_TCTL))
            rdata[RPT_LSB+2:RPT_LSB]   = rpt_o;
    end

    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata[FLAG_BIT] && !hit) |=> !flag_q);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int NF = NFIELD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] cur   [NF],
    input  logic [DW-1:0] alm   [NF],
    input  logic [2:0]    rpt,
    output logic          hit
);
    logic [NF-1:0] eq;
    logic [NF-1:0] use_m;
    logic          match;
    logic          prev_match_q;
    logic [DW-1:0] prev_hund_q;
    logic          wild_all, wild_tenth;

    assign use_m      = field_use(rpt);
    assign wild_all   = (rpt == RPT_PER_SEC) && (alm[0] == {DW{1'b1}});
    assign wild_tenth = (rpt == RPT_PER_SEC) && (alm[0][DW-1:DW-4] == 4'hF);

    for (genvar i = 0; i < NF; i++) begin : g_lane
        if (i == 0) begin : g_hund
            always_comb begin
                if (wild_all)
                    eq[i] = 1'b1;
                else if (wild_tenth)
                    eq[i] = (cur[i][3:0] == alm[i][3:0]);
                else
                    eq[i] = (cur[i] == alm[i]);
            end
        end else begin : g_plain
            assign eq[i] = (cur[i] == alm[i]);
        end
    end

    assign match = (rpt != 3'd0) && (&(eq | ~use_m));
    assign hit   = tick && match && (!prev_match_q || (cur[0] != prev_hund_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_match_q <= 1'b0;
            prev_hund_q  <= '0;
        end else if (tick) begin
            prev_match_q <= match;
            prev_hund_q  <= cur[0];
        end
    end
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hit,
    input  logic       flag_q,
    input  logic       aie_q,
    input  logic [1:0] im_q,
    input  logic       flag_nxt,
    input  logic       aie_nxt,
    input  logic [1:0] im_nxt,
    output logic       irq_n
);
    irq_state_e state_q, state_d;
    logic       level_want, pulse_go;

    assign level_want = flag_nxt && aie_nxt && (im_nxt == 2'b00);
    assign pulse_go   = hit && aie_nxt && (im_nxt != 2'b00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (pulse_go)        state_d = IRQ_PULSE;
                else if (level_want) state_d = IRQ_HOLD;
            end
            IRQ_PULSE: begin
                if (!aie_nxt)              state_d = IRQ_QUIET;
                else if (im_nxt == 2'b00)  state_d = level_want ? IRQ_HOLD : IRQ_QUIET;
                else if (tick && !hit)     state_d = IRQ_QUIET;
            end
            IRQ_HOLD: begin
                if (!level_want)     state_d = pulse_go ? IRQ_PULSE : IRQ_QUIET;
            end
            default:                 state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q == IRQ_QUIET);
    end

    // R12
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> aie_q);
    // R10
    level_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_q == 2'b00 && aie_q && flag_q) |-> !irq_n);
    // R10
    level_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_q == 2'b00 && !irq_n) |-> flag_q);
    // R11
    pulse_starts_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && im_q != 2'b00) |-> $past(hit));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DW-1:0]     cur_hund,
    input  logic [DW-1:0]     cur_sec,
    input  logic [DW-1:0]     cur_min,
    input  logic [DW-1:0]     cur_hour,
    input  logic [DW-1:0]     cur_date,
    input  logic [DW-1:0]     cur_month,
    input  logic [DW-1:0]     cur_wday,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_n
);
    localparam int NF = NFIELD;

    logic [DW-1:0] cur_arr [NF];
    logic [DW-1:0] alm_arr [NF];
    logic [2:0]    rpt;
    logic          hit, flag_q, aie_q, flag_nxt, aie_nxt;
    logic [1:0]    im_q, im_nxt;

    assign cur_arr[0] = cur_hund;
    assign cur_arr[1] = cur_sec;
    assign cur_arr[2] = cur_min;
    assign cur_arr[3] = cur_hour;
    assign cur_arr[4] = cur_date;
    assign cur_arr[5] = cur_month;
    assign cur_arr[6] = cur_wday;

    alarm_regs #(.ADDR_W(ADDR_W), .DW(DW), .NF(NF)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .hit(hit), .rdata(reg_rdata), .alm_o(alm_arr), .rpt_o(rpt),
        .flag_q(flag_q), .aie_q(aie_q), .im_q(im_q),
        .flag_nxt(flag_nxt), .aie_nxt(aie_nxt), .im_nxt(im_nxt)
    );

    alarm_match #(.DW(DW), .NF(NF)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cur(cur_arr), .alm(alm_arr),
        .rpt(rpt), .hit(hit)
    );

    irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit),
        .flag_q(flag_q), .aie_q(aie_q), .im_q(im_q),
        .flag_nxt(flag_nxt), .aie_nxt(aie_nxt), .im_nxt(im_nxt), .irq_n(irq_n)
    );

    // R3
    no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(rpt) != 3'd0));
    // R8
    flag_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));
endmodule

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         kind;   // 0 = read data, 1 = irq_n
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;
    logic [7:0] tv [7];
    logic [7:0] base [7];
    item_t      exp_q [$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_hund(tv[0]), .cur_sec(tv[1]), .cur_min(tv[2]), .cur_hour(tv[3]),
        .cur_date(tv[4]), .cur_month(tv[5]), .cur_wday(tv[6]),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            act = (it.kind == 0) ? reg_rdata : {7'b0, irq_n};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic tck();
        @(posedge clk); #1; tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        exp_q.push_back('{0, e, req});
        @(negedge clk);
    endtask

    task automatic expect_irq(input logic e, input string req);
        exp_q.push_back('{1, {7'b0, e}, req});
        @(negedge clk);
    endtask

    task automatic load_base();
        for (int i = 0; i < 7; i++) tv[i] = base[i];
    endtask

    // clear flag, then a non-matching tick so the next match counts as new
    task automatic prep();
        wr(6'h0F, 8'h00);
        tv[0] = 8'h99;
        tck();
    endtask

    function automatic bit compared(input int rpt, input int f);
        case (f)
            0: compared = 1'b1;
            1: compared = (rpt <= 6);
            2: compared = (rpt <= 5);
            3: compared = (rpt <= 4);
            4: compared = (rpt == 1 || rpt == 2);
            5: compared = (rpt == 1);
            default: compared = (rpt == 3);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        base[0] = 8'h50; base[1] = 8'h20; base[2] = 8'h15; base[3] = 8'h08;
        base[4] = 8'h14; base[5] = 8'h03; base[6] = 8'h02;
        for (int i = 0; i < 7; i++) tv[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(6'h08, 8'h00, "R1");
        expect_rd(6'h0F, 8'h00, "R1");
        expect_rd(6'h12, 8'h00, "R1");
        expect_rd(6'h18, 8'h00, "R1");
        expect_irq(1'b1, "R1");

        // R3 repeat 0: all fields 0 and time 0 still never sets the flag
        tck();
        expect_rd(6'h0F, 8'h00, "R3");

        // R2 readback and unused bits
        for (int i = 0; i < 7; i++) wr(6'(8 + i), 8'(8'h31 + i));
        for (int i = 0; i < 7; i++) expect_rd(6'(8 + i), 8'(8'h31 + i), "R2");
        wr(6'h18, 8'hFF);
        expect_rd(6'h18, 8'h1C, "R2");
        wr(6'h12, 8'hFF);
        expect_rd(6'h12, 8'h64, "R2");
        wr(6'h12, 8'h00);
        wr(6'h18, 8'h00);
        for (int i = 0; i < 7; i++) wr(6'(8 + i), base[i]);

        // R3 with a fully matching time
        load_base(); prep(); tv[0] = base[0]; tck();
        expect_rd(6'h0F, 8'h00, "R3");

        // R4 sweep: each repeat code, full match then one field off at a time
        for (int rpt = 1; rpt <= 7; rpt++) begin
            wr(6'h18, 8'(rpt << 2));
            for (int f = -1; f < 7; f++) begin
                load_base(); prep(); load_base();
                if (f >= 0) tv[f] = tv[f] ^ 8'h01;
                tck();
                expect_rd(6'h0F, (f < 0 || !compared(rpt, f)) ? 8'h04 : 8'h00, "R4");
            end
        end
        expect_irq(1'b1, "R12");

        // R5 PM bit in hours, daily repeat
        wr(6'h18, 8'h10);
        wr(6'h0B, 8'h28);
        load_base(); prep(); load_base(); tv[3] = 8'h08; tck();
        expect_rd(6'h0F, 8'h00, "R5");
        load_base(); tv[3] = 8'h28; prep(); tv[0] = base[0]; tck();
        expect_rd(6'h0F, 8'h04, "R5");
        wr(6'h0B, base[3]);

        // R6 every-hundredth wildcard
        wr(6'h18, 8'h1C);
        wr(6'h08, 8'hFF);
        load_base();
        wr(6'h0F, 8'h00); tv[0] = 8'h00; tck(); expect_rd(6'h0F, 8'h04, "R6");
        wr(6'h0F, 8'h00); tv[0] = 8'h37; tck(); expect_rd(6'h0F, 8'h04, "R6");
        wr(6'h0F, 8'h00); tv[0] = 8'h99; tck(); expect_rd(6'h0F, 8'h04, "R6");

        // R7 tenths wildcard, low digit 3
        wr(6'h08, 8'hF3);
        wr(6'h0F, 8'h00); tv[0] = 8'h43; tck(); expect_rd(6'h0F, 8'h04, "R7");
        wr(6'h0F, 8'h00); tv[0] = 8'h44; tck(); expect_rd(6'h0F, 8'h00, "R7");
        wr(6'h0F, 8'h00); tv[0] = 8'h03; tck(); expect_rd(6'h0F, 8'h04, "R7");

        // R8 stalled tick and no tick
        prep(); tv[0] = 8'h13; tck(); expect_rd(6'h0F, 8'h04, "R8");
        wr(6'h0F, 8'h00); tck(); expect_rd(6'h0F, 8'h00, "R8");
        tv[0] = 8'h23; repeat (4) @(posedge clk);
        expect_rd(6'h0F, 8'h00, "R8");
        tck(); expect_rd(6'h0F, 8'h04, "R8");

        // R9 write 1 keeps, write 0 clears, match beats clear
        wr(6'h0F, 8'hFF); expect_rd(6'h0F, 8'h04, "R9");
        wr(6'h0F, 8'h00); expect_rd(6'h0F, 8'h00, "R9");
        tv[0] = 8'h99; tck();
        tv[0] = 8'h33;
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 6'h0F; reg_wdata = 8'h00; tick = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; tick = 1'b0;
        expect_rd(6'h0F, 8'h04, "R9");

        // R10 level mode
        wr(6'h08, base[0]);
        wr(6'h12, 8'h04);
        prep(); expect_irq(1'b1, "R10");
        tv[0] = base[0]; tck(); expect_irq(1'b0, "R10");
        wr(6'h0F, 8'h00); expect_irq(1'b1, "R10");
        // R12 disabled: flag set, line high
        wr(6'h12, 8'h00);
        prep(); tv[0] = base[0]; tck();
        expect_irq(1'b1, "R12");
        expect_rd(6'h0F, 8'h04, "R12");
        wr(6'h12, 8'h04); expect_irq(1'b0, "R10");
        wr(6'h0F, 8'h00); expect_irq(1'b1, "R10");

        // R11 pulse mode
        wr(6'h12, 8'h24);
        prep(); tv[0] = base[0]; tck(); expect_irq(1'b0, "R11");
        repeat (3) @(posedge clk); #1;
        expect_irq(1'b0, "R11");
        tv[0] = 8'h51; tck(); expect_irq(1'b1, "R11");
        expect_rd(6'h0F, 8'h04, "R11");

        done = 1'b1;
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule